// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block collects 32 interrupt request lines, latches their events into a pending register and forwards the enabled ones to one of two processor request outputs. The two outputs are a normal request and a critical request. Each source is set up on its own for edge or level sensing and for either polarity. Software reaches every register through a simple word-wide bus. The bus carries a register offset, a read strobe, a write strobe and write data, and the read data is returned combinationally in the same cycle as the read strobe.

Pending bits are cleared by writing ones. A level source that is still active comes straight back, so the device must be quietened before its bit is cleared. For each output group the block also reports the highest-numbered pending source, so an interrupt handler can find the winner without scanning. These indices are available on ports and also through a read-only summary register. Generating vector addresses and chaining several controllers are left to the integrator.

Top module: `irq_ctrl32`

## Requirements
- R1: Source n (input line src_i[31-n]) occupies bit 31-n of every per-source register, so source 0 is the most significant bit.
- R2: Read/write registers sit at word offsets enable 0x2, critical 0x3, polarity 0x4 and trigger 0x5, and each reads back what was last written. Writes to offsets 0x1, 0x6, 0x7, 0x8 and above 0x8 have no effect. Offsets 0x1 and 0x8 and above read as zero. When the read strobe is low, read data is zero.
- R3: A source whose trigger bit is 1 is edge sensed. Its pending bit sets one clock after the input differs from its value on the previous clock in the chosen direction: rising when its polarity bit is 1, falling when it is 0. This happens whether or not the source is enabled.
- R4: A source whose trigger bit is 0 is level sensed. Its pending bit sets on each clock where the input equals its polarity bit, that is, high when the bit is 1 and low when it is 0.
- R5: Status at offset 0x0 reads the pending bits. Writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R6: A level-sensed source whose input is still active is pending again in the cycle after a clear, even when it is disabled.
- R7: Reading offset 0x6 returns status AND enable.
- R8: irq_norm_o is the OR of masked status over sources whose critical bit is 0. irq_crit_o is the same OR over sources whose critical bit is 1. Both are registered, so each follows masked status by one clock.
- R9: For each group, the id output gives the highest source number among the set masked-status bits of that group, and the valid output is high only if such a bit exists. When valid is low, the id is zero.
- R10: If an event and a write-one clear hit the same status bit in the same cycle, the bit stays set.
- R11: After reset, status, enable, critical and trigger are zero, polarity is all ones, and both request outputs are low.
- R12: Offset 0x7 reads the winners. Bits 4:0 hold the normal id and bit 7 the normal valid. Bits 12:8 hold the critical id and bit 15 the critical valid. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register word offset |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational, zero when not reading |
| src_i | input | 32 | Interrupt request lines, source n on bit 31-n |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |
| norm_id_o | output | 5 | Highest pending normal source number |
| norm_vld_o | output | 1 | A normal source is pending and enabled |
| crit_id_o | output | 5 | Highest pending critical source number |
| crit_vld_o | output | 1 | A critical source is pending and enabled |

## Verification
The properties assume that the request lines and bus inputs are synchronous to clk_i and stable around each rising edge. They also assume that read and write strobes are never both active. The bench changes every input only on the falling edge and issues each read or write alone. It holds each source at a level for at least one full cycle, so every edge is seen by the registered previous-value compare.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_ENABLE = 2;
  localparam int unsigned OFF_CRIT   = 3;
  localparam int unsigned OFF_POL    = 4;
  localparam int unsigned OFF_TRIG   = 5;
  localparam int unsigned OFF_MASKED = 6;
  localparam int unsigned OFF_WINNER = 7;
  // summary register field positions
  localparam int unsigned WIN_NVLD_BIT = 7;
  localparam int unsigned WIN_CID_LSB  = 8;
  localparam int unsigned WIN_CVLD_BIT = 15;
endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] trig_i,
  input  logic [NSRC-1:0] pol_i,
  output logic [NSRC-1:0] set_o
);
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    logic rise_w, fall_w, edge_w, lvl_w;
    assign rise_w = src_i[b] & ~prev_q[b];
    assign fall_w = ~src_i[b] & prev_q[b];
    assign edge_w = pol_i[b] ? rise_w : fall_w;
    assign lvl_w  = ~(src_i[b] ^ pol_i[b]);
    assign set_o[b] = trig_i[b] ? edge_w : lvl_w;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req_i,
  output logic [IW-1:0]   id_o,
  output logic            vld_o
);
  // lowest-order set bit is the highest source number
  always_comb begin
    id_o  = '0;
    vld_o = 1'b0;
    for (int b = NSRC - 1; b >= 0; b--) begin
      if (req_i[b]) begin
        id_o  = IW'(NSRC - 1 - b);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 4,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic            reg_rd_i,
  input  logic            reg_wr_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [NSRC-1:0] reg_rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_norm_o,
  output logic            irq_crit_o,
  output logic [IW-1:0]   norm_id_o,
  output logic            norm_vld_o,
  output logic [IW-1:0]   crit_id_o,
  output logic            crit_vld_o
);
  logic [NSRC-1:0] status_q, enable_q, crit_q, pol_q, trig_q;
  logic [NSRC-1:0] set_w, clr_w, masked_w, winner_w;

  irq_sense #(.NSRC(NSRC)) u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .trig_i (trig_q),
    .pol_i  (pol_q),
    .set_o  (set_w)
  );

  assign clr_w    = (reg_wr_i && reg_addr_i == AW'(OFF_STATUS)) ? reg_wdata_i : '0;
  assign masked_w = status_q & enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      crit_q   <= '0;
      pol_q    <= '1;
      trig_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_w) | set_w;  // set wins
      if (reg_wr_i) begin
        unique case (reg_addr_i)
          AW'(OFF_ENABLE): enable_q <= reg_wdata_i;
          AW'(OFF_CRIT):   crit_q   <= reg_wdata_i;
          AW'(OFF_POL):    pol_q    <= reg_wdata_i;
          AW'(OFF_TRIG):   trig_q   <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      irq_norm_o <= |(masked_w & ~crit_q);
      irq_crit_o <= |(masked_w & crit_q);
    end
  end

  irq_prio #(.NSRC(NSRC)) u_prio_norm (
    .req_i (masked_w & ~crit_q),
    .id_o  (norm_id_o),
    .vld_o (norm_vld_o)
  );

  irq_prio #(.NSRC(NSRC)) u_prio_crit (
    .req_i (masked_w & crit_q),
    .id_o  (crit_id_o),
    .vld_o (crit_vld_o)
  );

  always_comb begin
    winner_w = '0;
    winner_w[IW-1:0]              = norm_id_o;
    winner_w[WIN_NVLD_BIT]        = norm_vld_o;
    winner_w[WIN_CID_LSB +: IW]   = crit_id_o;
    winner_w[WIN_CVLD_BIT]        = crit_vld_o;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        AW'(OFF_STATUS): reg_rdata_o = status_q;
        AW'(OFF_ENABLE): reg_rdata_o = enable_q;
        AW'(OFF_CRIT):   reg_rdata_o = crit_q;
        AW'(OFF_POL):    reg_rdata_o = pol_q;
        AW'(OFF_TRIG):   reg_rdata_o = trig_q;
        AW'(OFF_MASKED): reg_rdata_o = masked_w;
        AW'(OFF_WINNER): reg_rdata_o = winner_w;
        default:         reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl32_chk.sv
module irq_ctrl32_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 4,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   reg_addr_i,
  input logic            reg_rd_i,
  input logic [NSRC-1:0] reg_rdata_o,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] enable_q,
  input logic [NSRC-1:0] crit_q,
  input logic [NSRC-1:0] pol_q,
  input logic [NSRC-1:0] trig_q,
  input logic            irq_norm_o,
  input logic            irq_crit_o,
  input logic [IW-1:0]   norm_id_o,
  input logic            norm_vld_o,
  input logic [IW-1:0]   crit_id_o,
  input logic            crit_vld_o
);
  logic [NSRC-1:0] msk_w, lvl_act_w;
  logic [IW-1:0]   nbit_w, cbit_w;
  assign msk_w     = status_q & enable_q;
  assign lvl_act_w = ~trig_q & ~(src_i ^ pol_q);
  assign nbit_w    = IW'(NSRC - 1) - norm_id_o;
  assign cbit_w    = IW'(NSRC - 1) - crit_id_o;

  assert_norm_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_norm_o == $past(|(msk_w & ~crit_q)));

  assert_crit_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_crit_o == $past(|(msk_w & crit_q)));

  assert_level_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_q & $past(lvl_act_w)) == $past(lvl_act_w));

  assert_norm_winner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_vld_o |-> (msk_w[nbit_w] && !crit_q[nbit_w]));

  assert_crit_winner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_vld_o |-> (msk_w[cbit_w] && crit_q[cbit_w]));

  assert_masked_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == AW'(OFF_MASKED)) |-> reg_rdata_o == msk_w);
endmodule

bind irq_ctrl32 irq_ctrl32_chk #(.NSRC(NSRC), .AW(AW)) u_chk (.*);

// File: tb/sim_irq_ctrl32.sv
module sim_irq_ctrl32;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  addr = '0;
  logic        rd = 0, wr = 0;
  logic [31:0] wdata = '0, src = '0;
  logic [31:0] rdata;
  logic        irq_n, irq_c, nvld, cvld;
  logic [4:0]  nid, cid;

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R11";

  irq_ctrl32 u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_i(src),
    .irq_norm_o(irq_n), .irq_crit_o(irq_c), .norm_id_o(nid), .norm_vld_o(nvld),
    .crit_id_o(cid), .crit_vld_o(cvld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [31:0] m_st, m_en, m_cr, m_po, m_tr, m_prv;
  logic        m_irqn, m_irqc;
  logic [31:0] t_set, t_clr, t_msk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_cr = 0; m_po = '1; m_tr = 0; m_prv = 0;
      m_irqn = 0; m_irqc = 0;
    end else begin
      t_msk = m_st & m_en;
      m_irqn = 0; m_irqc = 0;
      for (int n = 0; n < 32; n++) begin
        if (t_msk[31-n] && m_cr[31-n]) m_irqc = 1;
        if (t_msk[31-n] && !m_cr[31-n]) m_irqn = 1;
        if (m_tr[31-n])
          t_set[31-n] = m_po[31-n] ? (src[31-n] && !m_prv[31-n]) : (!src[31-n] && m_prv[31-n]);
        else
          t_set[31-n] = (src[31-n] == m_po[31-n]);
      end
      t_clr = (wr && addr == 4'h0) ? wdata : 32'h0;
      m_st = (m_st & ~t_clr) | t_set;
      if (wr) case (addr)
        4'h2: m_en = wdata;
        4'h3: m_cr = wdata;
        4'h4: m_po = wdata;
        4'h5: m_tr = wdata;
        default: ;
      endcase
      m_prv = src;
    end
  end

  task automatic pick(input logic [31:0] req, output logic [4:0] id, output logic v);
    id = 0; v = 0;
    for (int n = 0; n < 32; n++) if (req[31-n]) begin id = 5'(n); v = 1; end
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [4:0] e_nid, e_cid;
    logic e_nv, e_cv;
    logic [31:0] e_rd, m;
    m = m_st & m_en;
    pick(m & ~m_cr, e_nid, e_nv);
    pick(m & m_cr, e_cid, e_cv);
    e_rd = 0;
    if (rd) case (addr)
      4'h0: e_rd = m_st;
      4'h2: e_rd = m_en;
      4'h3: e_rd = m_cr;
      4'h4: e_rd = m_po;
      4'h5: e_rd = m_tr;
      4'h6: e_rd = m;
      4'h7: e_rd = {16'h0, e_cv, 2'b0, e_cid, e_nv, 2'b0, e_nid};
      default: e_rd = 0;
    endcase
    chk("rdata", rdata, e_rd);
    chk("irq_norm R8", {31'b0, irq_n}, {31'b0, m_irqn});
    chk("irq_crit R8", {31'b0, irq_c}, {31'b0, m_irqc});
    chk("norm_id R9", {27'b0, nid}, {27'b0, e_nid});
    chk("norm_vld R9", {31'b0, nvld}, {31'b0, e_nv});
    chk("crit_id R9", {27'b0, cid}, {27'b0, e_cid});
    chk("crit_vld R9", {31'b0, cvld}, {31'b0, e_cv});
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    tick(); addr = a; wdata = d; wr = 1; rd = 0;
    tick(); wr = 0;
  endtask

  task automatic reg_read(input logic [3:0] a);
    tick(); addr = a; rd = 1; wr = 0;
    tick(); rd = 0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 10; a++) reg_read(4'(a));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset values
    phase = "R11"; read_all();

    // R2: register read-back and ignored offsets
    phase = "R2";
    reg_write(4'h2, 32'h0);
    reg_write(4'h3, 32'hA5A5_0F0F); reg_write(4'h4, 32'hFFFF_FFFF);
    reg_write(4'h5, 32'h1234_5678); reg_write(4'h1, 32'hDEAD_BEEF);
    reg_write(4'h8, 32'hFFFF_FFFF); reg_write(4'h6, 32'hFFFF_FFFF);
    reg_write(4'h7, 32'hFFFF_FFFF); reg_write(4'hF, 32'hFFFF_FFFF);
    read_all(); reg_read(4'hF);
    reg_write(4'h3, 0); reg_write(4'h5, 0); reg_write(4'h0, '1);

    // R4 / R1: level high on source 3 (bit 28) while disabled
    phase = "R4"; tick(); src = 32'h1000_0000;
    reg_read(4'h0); reg_read(4'h6);
    reg_write(4'h2, 32'h1000_0000); reg_read(4'h6); reg_read(4'h7);
    // R1: source 0 sits on MSB
    phase = "R1"; tick(); src = 32'h9000_0000;
    reg_write(4'h2, 32'h9000_0000); reg_read(4'h7);

    // R6: clear while active re-sets, also when disabled
    phase = "R6"; reg_write(4'h0, 32'h9000_0000); reg_read(4'h0);
    reg_write(4'h2, 0); reg_write(4'h0, '1); reg_read(4'h0);
    tick(); src = 0; reg_write(4'h0, '1); reg_read(4'h0);

    // R4: active-low level on source 31 (bit 0)
    phase = "R4"; reg_write(4'h4, 32'hFFFF_FFFE); reg_read(4'h0);
    reg_write(4'h4, '1); reg_write(4'h0, '1); reg_read(4'h0);

    // R3: edge sensing, rising on bits 31:16, falling on 15:0
    phase = "R3";
    reg_write(4'h5, '1); reg_write(4'h4, 32'hFFFF_0000);
    reg_write(4'h0, '1); reg_write(4'h2, '1);
    tick(); src = 32'h0001_0001; reg_read(4'h0);
    tick(); src = 32'h0000_0000; reg_read(4'h0);
    reg_write(4'h0, '1); reg_read(4'h0); reg_read(4'h7);

    // R10: edge event and clear in the same cycle
    phase = "R10";
    tick(); src = 32'h0004_0000; addr = 4'h0; wdata = 32'h0004_0000; wr = 1;
    tick(); wr = 0; src = 0;
    reg_read(4'h0);

    // R5: write-zero keeps, write-one clears
    phase = "R5"; reg_write(4'h0, 32'h0); reg_read(4'h0);
    reg_write(4'h0, 32'h0004_0000); reg_read(4'h0);

    // R9 / R8 / R12: mixed groups with several pending
    phase = "R9";
    reg_write(4'h3, 32'h00F0_0000);
    tick(); src = 32'h8040_0300; tick(); src = 0;
    reg_read(4'h7); reg_read(4'h6);
    phase = "R12"; reg_read(4'h7);
    phase = "R8"; reg_write(4'h2, 32'h00F0_0000); reg_read(4'h6);
    reg_write(4'h2, 32'h0); reg_read(4'h7);
    reg_write(4'h0, '1); tick(); tick();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule